// File: doc/BRIEF.md
# Oscillator Settling Countdown After Stop

This block decides when the CPU clock may run again after the core has left its low-power stop state. A stop request moves it into a stopped state: the CPU clock is gated and the two countdown stages are frozen. When an external wake interrupt arrives, the block starts a countdown. An 8-bit prescaler is counted down on every oscillator clock, and each time it underflows it steps an 8-bit timer. The clock-release output goes high again only when the timer itself underflows.

The starting counts on wake come from one of two places, chosen by a control bit. With the bit clear (the reset default), hardware forces fixed settling counts: prescaler 0xFF and timer 0x01. With the bit set, the countdown uses whatever software wrote into the stages before stopping. Software reaches the stages and the control bit through a simple register write port. Writes to the stages are refused while the countdown is running.

Top module: `osc_settle_timer`

## Requirements
- R1: After reset, clk_release is 1, the block is in the running state and the reload-inhibit bit is 0.
- R2: A stop_req seen while running drives clk_release to 0 from the next clock edge. It stays 0 for as long as no wake_irq arrives.
- R3: The inhibit bit is bit 0 of the register at address 0x10; other bits of that write have no effect. If wake_irq arrives in the stopped state with the inhibit bit at 0, the prescaler is loaded with 0xFF and the timer with 0x01. clk_release then rises exactly 512 clocks after the wake edge.
- R4: With the inhibit bit at 1, a wake starts from the counts the stages held when stopped. Writes to the prescaler (address 0x01) and the timer (address 0x02) are accepted while running or stopped. With both stages written and no countdown since, clk_release rises (P+1)+T*(P+1) clocks after the wake edge, where P is the prescaler value and T is the timer value.
- R5: During the countdown the prescaler decrements once per clock. On its underflow it reloads its last written value and the timer decrements by one. The countdown ends when both stages are at zero on the same clock.
- R6: clk_release is 0 on every clock of the countdown and becomes 1 on the edge that underflows the timer.
- R7: Writes to the prescaler or timer during the countdown change neither the current countdown nor later ones.
- R8: wake_irq while running has no effect, and stop_req during the countdown has no effect: release comes at the normal time and the clock stays released.
- R9: At the end of a countdown each stage holds its reload value. A later inhibited stop with no writes in between therefore repeats the same length. After a fixed-count wake, that length is 512.
- R10: With the timer written as 0, an inhibited wake releases after P+1 clocks, and after 1 clock when both stages are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| stop_req | input | 1 | Request to enter the stopped state |
| wake_irq | input | 1 | External wake interrupt |
| clk_release | output | 1 | 1 when the CPU clock may run |

## Verification
The bench targets the exact release cycle, since a design that is off by one in the chained underflow would release a cycle early or late. The case that shows this most clearly is both stages at zero, where release must come after one clock. Writes and stop requests are injected during a countdown, and the following countdown is timed as well: a design that let such a write through would release early, either in that run or in the next one. A fixed-count wake followed by an inhibited wake checks that the fixed load also sets the reload values; a design that missed this would give a length other than 512. A write of 0xFE to the control register checks that only bit 0 is decoded.

// File: rtl/osc_settle_pkg.sv
package osc_settle_pkg;
  localparam int unsigned SET_CNT_W = 8;
  typedef logic [SET_CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_SETTLE = 2'd2
  } settle_state_e;

  // One step of a down-counting stage: wrap to its reload value at zero.
  function automatic cnt_t next_down(cnt_t cur, cnt_t reload);
    return (cur == '0) ? reload : cur - cnt_t'(1);
  endfunction
endpackage

// File: rtl/osc_settle_regs.sv
module osc_settle_regs
  import osc_settle_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PRE_ADDR  = 8'h01,
  parameter int unsigned TMR_ADDR  = 8'h02,
  parameter int unsigned MISC_ADDR = 8'h10,
  parameter int unsigned INH_BIT   = 0,
  parameter int unsigned FIX_PRE   = 8'hFF,
  parameter int unsigned FIX_TMR   = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  cnt_t              wr_data,
  input  logic              lock,
  input  logic              load_fixed,
  output logic              inhibit,
  output logic              pre_wr,
  output logic              tmr_wr,
  output cnt_t              pre_rld,
  output cnt_t              tmr_rld
);
  localparam cnt_t FIX_P = cnt_t'(FIX_PRE);
  localparam cnt_t FIX_T = cnt_t'(FIX_TMR);

  logic misc_wr;
  assign pre_wr  = wr_en && !lock && (wr_addr == ADDR_W'(PRE_ADDR));
  assign tmr_wr  = wr_en && !lock && (wr_addr == ADDR_W'(TMR_ADDR));
  assign misc_wr = wr_en && (wr_addr == ADDR_W'(MISC_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inhibit <= 1'b0;
      pre_rld <= FIX_P;
      tmr_rld <= FIX_T;
    end else begin
      if (misc_wr) inhibit <= wr_data[INH_BIT];
      if (load_fixed) begin
        pre_rld <= FIX_P;
        tmr_rld <= FIX_T;
      end else begin
        if (pre_wr) pre_rld <= wr_data;
        if (tmr_wr) tmr_rld <= wr_data;
      end
    end
  end
endmodule

// File: rtl/osc_settle_downcnt.sv
module osc_settle_downcnt
  import osc_settle_pkg::*;
#(
  parameter int unsigned RST_VAL = 8'hFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  cnt_t load_val,
  input  logic step,
  input  cnt_t reload_val,
  output cnt_t cnt,
  output logic is_zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= cnt_t'(RST_VAL);
    else if (load)  cnt <= load_val;
    else if (step)  cnt <= next_down(cnt, reload_val);
  end
  assign is_zero = (cnt == '0);
endmodule

// File: rtl/osc_settle_ctrl.sv
module osc_settle_ctrl
  import osc_settle_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic wake_irq,
  input  logic inhibit,
  input  logic underflow,
  output logic stopped,
  output logic counting,
  output logic load_fixed,
  output logic clk_release
);
  settle_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:    if (stop_req)  state_nx = ST_STOP;
      ST_STOP:   if (wake_irq)  state_nx = ST_SETTLE;
      ST_SETTLE: if (underflow) state_nx = ST_RUN;
      default:                  state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= state_nx;
  end

  assign stopped     = (state == ST_STOP);
  assign counting    = (state == ST_SETTLE);
  assign load_fixed  = stopped && wake_irq && !inhibit;
  assign clk_release = (state == ST_RUN);
endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer
  import osc_settle_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PRE_ADDR  = 8'h01,
  parameter int unsigned TMR_ADDR  = 8'h02,
  parameter int unsigned MISC_ADDR = 8'h10,
  parameter int unsigned INH_BIT   = 0,
  parameter int unsigned FIX_PRE   = 8'hFF,
  parameter int unsigned FIX_TMR   = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              stop_req,
  input  logic              wake_irq,
  output logic              clk_release
);
  localparam int unsigned NSTG = 2;

  logic inhibit, pre_wr, tmr_wr, stopped, counting, load_fixed, underflow;
  cnt_t pre_rld, tmr_rld, pre_cnt, tmr_cnt;

  cnt_t stg_cnt  [NSTG];
  cnt_t stg_rld  [NSTG];
  cnt_t stg_fix  [NSTG];
  logic stg_wr   [NSTG];
  logic stg_zero [NSTG];
  logic stg_step [NSTG];

  osc_settle_regs #(
    .ADDR_W(ADDR_W), .PRE_ADDR(PRE_ADDR), .TMR_ADDR(TMR_ADDR),
    .MISC_ADDR(MISC_ADDR), .INH_BIT(INH_BIT),
    .FIX_PRE(FIX_PRE), .FIX_TMR(FIX_TMR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lock(counting), .load_fixed(load_fixed),
    .inhibit(inhibit), .pre_wr(pre_wr), .tmr_wr(tmr_wr),
    .pre_rld(pre_rld), .tmr_rld(tmr_rld)
  );

  osc_settle_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_irq(wake_irq),
    .inhibit(inhibit), .underflow(underflow), .stopped(stopped),
    .counting(counting), .load_fixed(load_fixed), .clk_release(clk_release)
  );

  // Stage 0 is the prescaler, stage 1 the timer; each steps on the
  // underflow of the stage below it.
  for (genvar i = 0; i < NSTG; i++) begin : g_stage
    localparam int unsigned FIXV = (i == 0) ? FIX_PRE : FIX_TMR;
    assign stg_rld[i] = (i == 0) ? pre_rld : tmr_rld;
    assign stg_wr[i]  = (i == 0) ? pre_wr  : tmr_wr;
    assign stg_fix[i] = cnt_t'(FIXV);
    if (i == 0) begin : g_first
      assign stg_step[i] = counting;
    end else begin : g_next
      assign stg_step[i] = stg_step[i-1] && stg_zero[i-1];
    end
    osc_settle_downcnt #(.RST_VAL(FIXV)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .load(load_fixed || stg_wr[i]),
      .load_val(load_fixed ? stg_fix[i] : wr_data),
      .step(stg_step[i]), .reload_val(stg_rld[i]),
      .cnt(stg_cnt[i]), .is_zero(stg_zero[i])
    );
  end

  assign underflow = stg_step[NSTG-1] && stg_zero[NSTG-1];
  assign pre_cnt   = stg_cnt[0];
  assign tmr_cnt   = stg_cnt[1];
endmodule

// File: rtl/osc_settle_checks.sv
module osc_settle_checks
  import osc_settle_pkg::*;
#(
  parameter int unsigned FIX_PRE = 8'hFF,
  parameter int unsigned FIX_TMR = 8'h01
) (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic wake_irq,
  input logic stopped,
  input logic counting,
  input logic underflow,
  input logic load_fixed,
  input logic clk_release,
  input cnt_t pre_cnt,
  input cnt_t tmr_cnt
);
  assert_frozen_in_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !wr_en && !wake_irq) |=> ($stable(pre_cnt) && $stable(tmr_cnt)));

  assert_fixed_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_fixed |=> (pre_cnt == cnt_t'(FIX_PRE) && tmr_cnt == cnt_t'(FIX_TMR)));

  assert_prescaler_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && pre_cnt != '0) |=> (pre_cnt == $past(pre_cnt) - cnt_t'(1)));

  assert_release_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_release) |-> $past(underflow));

  assert_gated_while_counting_R6: assert property (@(posedge clk) disable iff (!rst_n)
    counting |-> !clk_release);

  assert_release_after_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> clk_release);
endmodule

bind osc_settle_timer osc_settle_checks #(.FIX_PRE(FIX_PRE), .FIX_TMR(FIX_TMR)) u_checks (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wake_irq(wake_irq),
  .stopped(stopped), .counting(counting), .underflow(underflow),
  .load_fixed(load_fixed), .clk_release(clk_release),
  .pre_cnt(pre_cnt), .tmr_cnt(tmr_cnt)
);

// File: tb/test_osc_settle_timer.sv
`timescale 1ns/1ps
module test_osc_settle_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       stop_req = 1'b0;
  logic       wake_irq = 1'b0;
  logic       clk_release;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_PRE = 8'h01, A_TMR = 8'h02, A_MISC = 8'h10;

  always #2 clk = ~clk;

  osc_settle_timer i_osc_settle_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stop_req(stop_req), .wake_irq(wake_irq),
    .clk_release(clk_release)
  );

  task automatic check(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: mode 0 running, 1 stopped, 2 counting down.
  int m_mode = 0, m_left = 0, m_lp = 255, m_lt = 1;
  bit m_inh = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_lp = 255; m_lt = 1; m_inh = 1'b0; m_left = 0;
    end else begin
      if (wr_en && wr_addr == A_MISC) m_inh = wr_data[0];
      if (wr_en && m_mode != 2 && wr_addr == A_PRE) m_lp = wr_data;
      if (wr_en && m_mode != 2 && wr_addr == A_TMR) m_lt = wr_data;
      case (m_mode)
        0: if (stop_req) m_mode = 1;
        1: if (wake_irq) begin
             if (!m_inh) begin m_lp = 255; m_lt = 1; end
             m_left = (m_lp + 1) * (m_lt + 1);
             m_mode = 2;
           end
        default: begin
          m_left--;
          if (m_left == 0) m_mode = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (m_mode == 2)      check(clk_release, 0, "R6 per-cycle");
      else if (m_mode == 1) check(clk_release, 0, "R2 per-cycle");
      else                  check(clk_release, 1, "R1 per-cycle");
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic enter_stop();
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
  endtask

  // poke: 0 none, 1 counter writes mid-countdown, 2 stop_req mid-countdown
  task automatic wake_measure(int exp, string tag, int poke);
    int n;
    wake_irq = 1'b1;
    @(negedge clk);
    wake_irq = 1'b0;
    n = 1;
    while (!clk_release && n < 5000) begin
      if (poke == 1 && n == 3) begin wr_en = 1'b1; wr_addr = A_PRE; wr_data = 8'h00; end
      if (poke == 1 && n == 4) begin wr_addr = A_TMR; end
      if (poke == 1 && n == 5) wr_en = 1'b0;
      if (poke == 2 && n == 3) stop_req = 1'b1;
      if (poke == 2 && n == 4) stop_req = 1'b0;
      @(negedge clk);
      n++;
    end
    wr_en = 1'b0; stop_req = 1'b0;
    check(n - 1, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(clk_release, 1, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(clk_release, 1, "R1 after reset");

    wake_irq = 1'b1; @(negedge clk); wake_irq = 1'b0;
    repeat (3) @(negedge clk);
    check(clk_release, 1, "R8 wake while running");

    enter_stop();
    repeat (5) @(negedge clk);
    check(clk_release, 0, "R2 held in stop");
    wake_measure(512, "R3 fixed counts", 0);

    wr(A_MISC, 8'h01); wr(A_PRE, 8'd3); wr(A_TMR, 8'd2);
    enter_stop();
    wake_measure(12, "R4 inhibited wake", 0);
    enter_stop();
    wake_measure(12, "R9 repeat without writes", 0);
    enter_stop();
    wake_measure(12, "R7 writes during countdown", 1);
    enter_stop();
    wake_measure(12, "R7 later countdown unchanged", 0);
    enter_stop();
    wake_measure(12, "R8 stop_req during countdown", 2);
    repeat (4) @(negedge clk);
    check(clk_release, 1, "R8 stays released");

    wr(A_PRE, 8'd7); wr(A_TMR, 8'd3);
    enter_stop();
    wake_measure(32, "R5 chained underflow", 0);

    wr(A_PRE, 8'd5); wr(A_TMR, 8'd0);
    enter_stop();
    wake_measure(6, "R10 timer zero", 0);
    wr(A_PRE, 8'd0);
    enter_stop();
    wake_measure(1, "R10 both zero", 0);

    enter_stop();
    wr(A_PRE, 8'd1); wr(A_TMR, 8'd1);
    wake_measure(4, "R4 write while stopped", 0);

    wr(A_MISC, 8'hFE);
    enter_stop();
    wake_measure(512, "R3 only bit 0 decoded", 0);
    wr(A_MISC, 8'h01);
    enter_stop();
    wake_measure(512, "R9 fixed load sets reload", 0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    done = 1'b1;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule